// File: doc/BRIEF.md
# Burst-of-Two Dual-Port SRAM Front End

This block is the command and data capture logic of a synchronous memory that has one read data port, one write data port and a single address bus shared by the two halves of each clock cycle. A half-cycle phase input marks every edge of the block clock as either the first or the second half of a memory cycle. On the first-half edge the block samples both port selects, the read address, the first write word and its byte enables. On the second-half edge it samples the write address, the second write word and its byte enables. So every memory cycle can accept one read and one write.

Each write burst is held as a single wide entry made of two words. Each 9-bit byte lane of either word can be masked. A read returns both words of an entry in write order, 1.5 memory cycles after the request, with an output-enable flag that is high only while a beat is on the output. A read and a write to the same address in the same cycle return the freshly merged data.

Top module: `qb2_sram_front`

## Requirements
- R1: The read and write selects are active low and take effect only when sampled on a first-half edge (`half_ph`=0); their values on second-half edges (`half_ph`=1) start nothing.
- R2: The read address is taken on the first-half edge and the write address on the second-half edge of the same cycle, so a read and a write to different addresses can both be accepted in every cycle.
- R3: The first write word and its byte enables are taken on the first-half edge, and the second word and its own enables on the second-half edge. They are stored as one entry, and a read returns the first word and then the second.
- R4: Byte enables are active low. Enable bit l covers data bits 9l+8 down to 9l of its word. A lane whose enable is high keeps its previously stored value.
- R5: A write is in the array by the end of the cycle that carries its second word, and a read issued in any later cycle returns it.
- R6: A read and a write to the same address in the same cycle return the new merged entry. A read of a different address in that cycle returns that address's stored entry.
- R7: For a read sampled on first-half edge n, the first word is on `q` after edge n+3 (a second-half edge) and the second word after edge n+4.
- R8: `q_oe` is low after reset and on every edge that carries no read beat. `q` is all zeros whenever `q_oe` is low.
- R9: Deselecting the read port does not cancel a read already accepted. Both beats still appear, and `q_oe` goes low after the edge that follows the second beat.
- R10: While a port is deselected, its address, data and enable inputs have no effect: no array entry changes, and no read is started.
- R11: Reads on consecutive cycles produce an unbroken stream of beats with `q_oe` held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock; each rising edge is one half of a memory cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| half_ph | input | 1 | 0 on first-half edges, 1 on second-half edges |
| rd_sel_n | input | 1 | Read port select, active low |
| wr_sel_n | input | 1 | Write port select, active low |
| addr | input | AW | Shared address: read address in the first half, write address in the second |
| din | input | W | Write data word |
| ben_n | input | LANES | Byte enables for the current word, active low |
| q | output | W | Read data beat |
| q_oe | output | 1 | High while `q` carries a valid beat |

## Verification
The bench first fills every address with full-width bursts while reading back the address written one cycle earlier. It then streams reads of all addresses back to back. This separates the address-phase split, the word order and the continuous beat stream. All sixteen mask values are swept over both words of a burst, which exposes any lane decode or a half-word mix-up. Same-address and neighbouring-address read/write pairs in one cycle separate forwarding from a plain array read. Cycles with a deselected port, junk addresses and selects asserted only in the second half show whether the block acts on input it should ignore. An isolated read followed by idle cycles shows that the enable drops right after the second beat.

// File: rtl/qb2_pkg.sv
package qb2_pkg;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } qb2_phase_e;

    localparam int QB2_LANE_W_DEF = 9;
    localparam int QB2_LANES_DEF  = 4;
    localparam int QB2_DEPTH_DEF  = 16;

endpackage

// File: rtl/qb2_capture.sv
module qb2_capture
    import qb2_pkg::*;
#(
    parameter int AW    = 4,
    parameter int W     = 36,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             half_ph,
    input  logic             rd_sel_n,
    input  logic             wr_sel_n,
    input  logic [AW-1:0]    addr,
    input  logic [W-1:0]     din,
    input  logic [LANES-1:0] ben_n,
    output logic             rd_go,
    output logic [AW-1:0]    rd_addr,
    output logic             wr_go,
    output logic [AW-1:0]    wr_addr,
    output logic [W-1:0]     wd0,
    output logic [LANES-1:0] be0,
    output logic [W-1:0]     wd1,
    output logic [LANES-1:0] be1
);

    typedef struct packed {
        logic             rd_pend;
        logic [AW-1:0]    rd_addr;
        logic             wr_pend;
        logic [W-1:0]     wd0;
        logic [LANES-1:0] be0;
    } cap_t;

    cap_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (half_ph == PH_FIRST) begin
            s_d.rd_pend = ~rd_sel_n;
            if (!rd_sel_n) begin
                s_d.rd_addr = addr;
            end
            s_d.wr_pend = ~wr_sel_n;
            if (!wr_sel_n) begin
                s_d.wd0 = din;
                s_d.be0 = ~ben_n;
            end
        end else begin
            s_d.rd_pend = 1'b0;
            s_d.wr_pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_go   = s_q.rd_pend && (half_ph == PH_SECOND);
    assign rd_addr = s_q.rd_addr;
    assign wr_go   = s_q.wr_pend && (half_ph == PH_SECOND);
    assign wr_addr = addr;
    assign wd0     = s_q.wd0;
    assign be0     = s_q.be0;
    assign wd1     = din;
    assign be1     = ~ben_n;

    // R2: halves of a memory cycle alternate
    a_r2_phase_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        (half_ph == PH_SECOND) |=> (half_ph == PH_FIRST));

    // R10: a deselected read leaves the held read address alone
    a_r10_rd_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (half_ph == PH_FIRST && rd_sel_n) |=> $stable(rd_addr));

endmodule

// File: rtl/qb2_array.sv
module qb2_array #(
    parameter int DEPTH  = 16,
    parameter int AW     = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int W      = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    rd_addr,
    input  logic             wr_go,
    input  logic [AW-1:0]    wr_addr,
    input  logic [W-1:0]     wd0,
    input  logic [LANES-1:0] be0,
    input  logic [W-1:0]     wd1,
    input  logic [LANES-1:0] be1,
    output logic [2*W-1:0]   rd_entry
);

    localparam int EW = 2 * W;

    logic [EW-1:0] mem [DEPTH];
    logic [EW-1:0] old_entry;
    logic [EW-1:0] new_entry;
    logic          fwd_hit;

    assign old_entry = mem[wr_addr];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign new_entry[l*LANE_W +: LANE_W] = be0[l] ? wd0[l*LANE_W +: LANE_W]
                                                      : old_entry[l*LANE_W +: LANE_W];
        assign new_entry[W + l*LANE_W +: LANE_W] = be1[l] ? wd1[l*LANE_W +: LANE_W]
                                                          : old_entry[W + l*LANE_W +: LANE_W];

        // R4: a masked lane of either word keeps its old contents
        a_r4_lane_kept_w0: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_go && !be0[l]) |=>
            mem[$past(wr_addr)][l*LANE_W +: LANE_W] == $past(old_entry[l*LANE_W +: LANE_W]));
        a_r4_lane_kept_w1: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_go && !be1[l]) |=>
            mem[$past(wr_addr)][W + l*LANE_W +: LANE_W] == $past(old_entry[W + l*LANE_W +: LANE_W]));
    end

    assign fwd_hit  = wr_go && (wr_addr == rd_addr);
    assign rd_entry = fwd_hit ? new_entry : mem[rd_addr];

    always_ff @(posedge clk) begin
        if (wr_go) begin
            mem[wr_addr] <= new_entry;
        end
    end

    // R5: a committed burst is in the array on the following edge
    a_r5_commit_visible: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> mem[$past(wr_addr)] == $past(new_entry));

endmodule

// File: rtl/qb2_beats.sv
module qb2_beats
    import qb2_pkg::*;
#(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         half_ph,
    input  logic         rd_go,
    input  logic [2*W-1:0] rd_entry,
    output logic [W-1:0] q,
    output logic         q_oe
);

    typedef struct packed {
        logic           a_vld;
        logic [2*W-1:0] a_w;
        logic           b_vld;
        logic [W-1:0]   b_w;
        logic [W-1:0]   q;
        logic           oe;
    } beat_t;

    beat_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (half_ph == PH_SECOND) begin
            if (s_q.a_vld) begin
                s_d.q     = s_q.a_w[W-1:0];
                s_d.oe    = 1'b1;
                s_d.b_w   = s_q.a_w[2*W-1:W];
                s_d.b_vld = 1'b1;
            end else begin
                s_d.q     = '0;
                s_d.oe    = 1'b0;
                s_d.b_vld = 1'b0;
            end
            s_d.a_vld = rd_go;
            if (rd_go) begin
                s_d.a_w = rd_entry;
            end
        end else begin
            if (s_q.b_vld) begin
                s_d.q  = s_q.b_w;
                s_d.oe = 1'b1;
            end else begin
                s_d.q  = '0;
                s_d.oe = 1'b0;
            end
            s_d.b_vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign q    = s_q.q;
    assign q_oe = s_q.oe;

    // R8: a disabled output carries zeros
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !q_oe |-> (q == '0));

    // R9: once a burst starts on the output, its second beat follows
    a_r9_second_beat: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_oe) |=> q_oe);

    // R7: a burst starts on a second-half edge
    a_r7_start_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_oe) |-> ($past(half_ph) == PH_SECOND));

endmodule

// File: rtl/qb2_sram_front.sv
module qb2_sram_front
    import qb2_pkg::*;
#(
    parameter int DEPTH  = QB2_DEPTH_DEF,
    parameter int LANES  = QB2_LANES_DEF,
    parameter int LANE_W = QB2_LANE_W_DEF,
    localparam int AW    = $clog2(DEPTH),
    localparam int W     = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             half_ph,
    input  logic             rd_sel_n,
    input  logic             wr_sel_n,
    input  logic [AW-1:0]    addr,
    input  logic [W-1:0]     din,
    input  logic [LANES-1:0] ben_n,
    output logic [W-1:0]     q,
    output logic             q_oe
);

    logic             rd_go;
    logic [AW-1:0]    rd_addr;
    logic             wr_go;
    logic [AW-1:0]    wr_addr;
    logic [W-1:0]     wd0;
    logic [LANES-1:0] be0;
    logic [W-1:0]     wd1;
    logic [LANES-1:0] be1;
    logic [2*W-1:0]   rd_entry;

    qb2_capture #(.AW(AW), .W(W), .LANES(LANES)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_ph  (half_ph),
        .rd_sel_n (rd_sel_n),
        .wr_sel_n (wr_sel_n),
        .addr     (addr),
        .din      (din),
        .ben_n    (ben_n),
        .rd_go    (rd_go),
        .rd_addr  (rd_addr),
        .wr_go    (wr_go),
        .wr_addr  (wr_addr),
        .wd0      (wd0),
        .be0      (be0),
        .wd1      (wd1),
        .be1      (be1)
    );

    qb2_array #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES), .LANE_W(LANE_W), .W(W)) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (rd_addr),
        .wr_go    (wr_go),
        .wr_addr  (wr_addr),
        .wd0      (wd0),
        .be0      (be0),
        .wd1      (wd1),
        .be1      (be1),
        .rd_entry (rd_entry)
    );

    qb2_beats #(.W(W)) u_beats (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_ph  (half_ph),
        .rd_go    (rd_go),
        .rd_entry (rd_entry),
        .q        (q),
        .q_oe     (q_oe)
    );

endmodule

// File: tb/qb2_sram_front_test.sv
module qb2_sram_front_test;

    localparam int CLK_P  = 10;
    localparam int DEPTH  = 16;
    localparam int LANES  = 4;
    localparam int LW     = 9;
    localparam int W      = LANES * LW;
    localparam int AW     = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             half_ph = 1'b0;
    logic             rd_sel_n = 1'b1;
    logic             wr_sel_n = 1'b1;
    logic [AW-1:0]    addr = '0;
    logic [W-1:0]     din = '0;
    logic [LANES-1:0] ben_n = '1;
    logic [W-1:0]     q;
    logic             q_oe;

    int total = 0;
    int bad   = 0;
    int edge_n = 0;

    logic [2*W-1:0] ref_mem [int];
    logic [W-1:0]   exp_q   [int];
    string          exp_tag [int];
    string          exp_off [int];

    always #(CLK_P/2) clk = ~clk;

    qb2_sram_front uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_ph  (half_ph),
        .rd_sel_n (rd_sel_n),
        .wr_sel_n (wr_sel_n),
        .addr     (addr),
        .din      (din),
        .ben_n    (ben_n),
        .q        (q),
        .q_oe     (q_oe)
    );

    function automatic logic [W-1:0] pat(int k);
        logic [39:0] t;
        t = {32'(k * 32'h9E37_79B1), 8'(k ^ 8'h5A)};
        return t[W-1:0];
    endfunction

    task automatic check_edge(int k);
        logic [W-1:0] eq;
        logic         eo;
        string        tg;
        if (exp_q.exists(k)) begin
            eo = 1'b1; eq = exp_q[k]; tg = exp_tag[k];
        end else begin
            eo = 1'b0; eq = '0; tg = exp_off.exists(k) ? exp_off[k] : "R8";
        end
        total++;
        if (q_oe !== eo || q !== eq) begin
            bad++;
            $display("FAIL %s edge %0d: oe=%0b q=%h expected oe=%0b q=%h", tg, k, q_oe, q, eo, eq);
        end
    endtask

    task automatic half(input logic ph, input logic rdn, input logic wrn,
                        input logic [AW-1:0] a, input logic [W-1:0] d,
                        input logic [LANES-1:0] bn);
        @(negedge clk);
        check_edge(edge_n);
        half_ph  = ph;
        rd_sel_n = rdn;
        wr_sel_n = wrn;
        addr     = a;
        din      = d;
        ben_n    = bn;
        @(posedge clk);
        edge_n++;
    endtask

    // one memory cycle with reference model update
    task automatic cyc(input logic rd, input logic [AW-1:0] ra,
                       input logic wr, input logic [AW-1:0] wa,
                       input logic [W-1:0] d0, input logic [LANES-1:0] b0n,
                       input logic [W-1:0] d1, input logic [LANES-1:0] b1n,
                       input string tg0, input string tg1);
        int e0;
        logic [2*W-1:0] oldv, newv, rv;
        half(1'b0, !rd, !wr, rd ? ra : ~ra, d0, b0n);
        e0 = edge_n;
        // second half: selects asserted to show they start nothing (R1)
        half(1'b1, 1'b0, 1'b0, wr ? wa : ~wa, d1, b1n);
        oldv = ref_mem.exists(int'(wa)) ? ref_mem[int'(wa)] : '0;
        newv = oldv;
        for (int l = 0; l < LANES; l++) begin
            if (!b0n[l]) newv[l*LW +: LW] = d0[l*LW +: LW];
            if (!b1n[l]) newv[W + l*LW +: LW] = d1[l*LW +: LW];
        end
        if (rd) begin
            rv = ref_mem.exists(int'(ra)) ? ref_mem[int'(ra)] : '0;
            if (wr && wa == ra) rv = newv;
            exp_q[e0+3]   = rv[W-1:0];
            exp_tag[e0+3] = tg0;
            exp_q[e0+4]   = rv[2*W-1:W];
            exp_tag[e0+4] = tg1;
        end
        if (wr) ref_mem[int'(wa)] = newv;
    endtask

    task automatic idle(int n, input string tg);
        for (int i = 0; i < n; i++) begin
            exp_off[edge_n+1] = tg;
            exp_off[edge_n+2] = tg;
            cyc(1'b0, 4'(i), 1'b0, 4'(i + 7), pat(900 + i), '0, pat(950 + i), '0, tg, tg);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state
        total++;
        if (q_oe !== 1'b0 || q !== '0) begin
            bad++;
            $display("FAIL R8 reset: oe=%0b q=%h expected oe=0 q=0", q_oe, q);
        end

        // R2 R3 R5: fill every address, read the one written a cycle earlier
        for (int a = 0; a < DEPTH; a++) begin
            cyc(a > 0, 4'(a - 1), 1'b1, 4'(a), pat(2*a), '0, pat(2*a + 1), '0, "R2", "R5");
        end
        // R11 R7 R3: back-to-back read sweep
        for (int a = 0; a < DEPTH; a++) begin
            cyc(1'b1, 4'(a), 1'b0, 4'(a), pat(500 + a), '0, pat(600 + a), '0, "R7", "R11");
        end
        idle(2, "R9");

        // R4 R5: all mask values on both words
        for (int m = 0; m < 16; m++) begin
            cyc(1'b0, 4'(m), 1'b1, 4'(m), pat(100 + m), 4'(m), pat(200 + m), ~4'(m), "R4", "R4");
            cyc(1'b1, 4'(m), 1'b0, 4'(m), pat(0), '0, pat(0), '0, "R4", "R5");
        end

        // R6: same-cycle forwarding and neighbouring address
        for (int m = 0; m < 16; m++) begin
            cyc(1'b1, 4'(m), 1'b1, 4'(m), pat(300 + m), 4'(m), pat(350 + m), 4'(m) ^ 4'h5, "R6", "R6");
            cyc(1'b1, 4'(m), 1'b1, 4'(m) ^ 4'h1, pat(400 + m), 4'h0, pat(450 + m), 4'h3, "R6", "R6");
        end
        idle(2, "R9");

        // R10 R1: deselected ports with junk address and data
        for (int m = 0; m < 4; m++) begin
            exp_off[edge_n+3] = "R1";
            exp_off[edge_n+4] = "R1";
            cyc(1'b0, 4'(m), 1'b0, 4'(m), pat(700 + m), '0, pat(800 + m), '0, "R1", "R1");
        end
        for (int m = 0; m < 4; m++) begin
            cyc(1'b1, 4'(m), 1'b0, 4'(m), pat(0), '1, pat(0), '1, "R10", "R10");
        end
        idle(2, "R9");

        // R9: isolated read then deselect; enable drops after second beat
        for (int m = 0; m < 3; m++) begin
            cyc(1'b1, 4'(m + 5), 1'b0, 4'(m), pat(0), '1, pat(0), '1, "R9", "R9");
            idle(2, "R9");
        end

        idle(2, "R8");
        @(negedge clk);
        check_edge(edge_n);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule